// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Timing

This block is a single-direction, 36-bit wide first-in first-out buffer between two free-running clock domains. The write port and the read port each have their own clock. The two clocks may be unrelated, or they may be the same clock. The storage depth is a power of two set by a parameter, for example 2048, 4096 or 8192 words. A bidirectional link is built from two instances placed back to back. Each instance is cleared by its own reset input.

A static mode input picks the flag timing. In standard mode the status pins report full and empty. A word reaches the read data output only on the clock after an enabled read. In fall-through mode the same pins report input-ready and output-ready. The oldest word is moved into an output register without any read request, and output-ready marks it valid. A read enable then consumes that word.

Two more flags warn that the FIFO is nearly full or nearly empty. Each compares a count against an offset. The offset is a fixed default picked by a two-bit select input, or, when the select is zero, a register written directly from the matching clock domain.

Top module: `dcfifo_dualtiming`

## Requirements
- R1: Words leave the read port in the order they were written, with all 36 bits intact, whether the clocks are coincident or unrelated.
- R2: Standard mode (`fwft`=0): `empty_or` is 1 exactly when no word is readable. `rdata` takes the next word on the read-clock edge that samples `ren`=1 while the FIFO is not empty, and holds its value otherwise.
- R3: Standard mode: `full_ir` is 1 exactly when DEPTH words are stored. A write while full stores nothing and leaves the write pointer unchanged.
- R4: A read while nothing is readable (standard-mode empty, or fall-through output-ready low) leaves `rdata` and the read pointer unchanged.
- R5: Fall-through mode (`fwft`=1): once a word is stored it appears on `rdata` and `empty_or` (output-ready) rises without any `ren`. The word and the flag hold until a read-clock edge samples `ren`=1.
- R6: Fall-through mode: `full_ir` (input-ready) is 1 while the storage array holds fewer than DEPTH words. Counting the output register, DEPTH+1 words can be held in total.
- R7: `aempty` is 1 when the readable word count is at or below the almost-empty offset. In fall-through mode the readable count includes a valid output register.
- R8: `afull` is 1 when DEPTH minus the number of words in the storage array is at or below the almost-full offset.
- R9: `fsel` codes 1, 2 and 3 select an offset of 8, 16 and 64 for both almost flags. Code 0 uses registers that reset to 0. The almost-full register is loaded by `af_ofs_we` on `wclk`, and the almost-empty register is loaded by `ae_ofs_we` on `rclk`.
- R10: A flag changes on the first edge of its own clock when that edge is the cause. A change caused from the other domain appears after two extra edges of the flag's clock. For example, in standard mode `empty_or` falls after the second read-clock edge that follows the write edge.
- R11: A write and a read sampled on the same edge of coincident clocks both take effect.
- R12: While `rst_n` is low and after it is released: pointers are cleared, `empty_or` reads empty (standard mode 1, fall-through 0), `full_ir` shows not full, and `aempty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for this FIFO, released per domain |
| fwft | input | 1 | Flag timing: 0 standard, 1 fall-through (change only during reset) |
| fsel | input | 2 | Almost-flag offset select (0 = programmed registers) |
| wen | input | 1 | Write enable, sampled on wclk |
| wdata | input | DW | Write data |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through), wclk domain |
| afull | output | 1 | Almost-full flag, wclk domain |
| af_ofs_we | input | 1 | Load strobe for the almost-full offset register, wclk domain |
| af_ofs_val | input | OFS_W | Almost-full offset value |
| ren | input | 1 | Read enable, sampled on rclk |
| rdata | output | DW | Read data |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through), rclk domain |
| aempty | output | 1 | Almost-empty flag, rclk domain |
| ae_ofs_we | input | 1 | Load strobe for the almost-empty offset register, rclk domain |
| ae_ofs_val | input | OFS_W | Almost-empty offset value |

## Verification
The two functions that can fall in the same cycle are a write and a read on one shared clock edge. The bench provokes this by tying both clocks to one source, pre-filling four words, and then asserting `wen` and `ren` together for twenty consecutive edges. Each read result is compared against the arithmetic pattern of the word written four positions earlier. Afterwards the four words still inside are drained, which confirms that no write was lost and that no extra word was created while both pointers moved on the same edge.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  localparam int OFS_SEL1 = 8;
  localparam int OFS_SEL2 = 16;
  localparam int OFS_SEL3 = 64;

  // fixed almost-flag offset for a nonzero select code
  function automatic logic [15:0] dflt_ofs(input logic [1:0] sel);
    case (sel)
      2'd1:    return 16'(OFS_SEL1);
      2'd2:    return 16'(OFS_SEL2);
      2'd3:    return 16'(OFS_SEL3);
      default: return 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 36,
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store_q[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (re)  rdata <= store_q[raddr];
  end

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW    = 11,
  parameter int OFS_W = 8
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wen,
  input  logic             fwft,
  input  logic [1:0]       fsel,
  input  logic             af_we,
  input  logic [OFS_W-1:0] af_val,
  input  logic [AW:0]      rgray_s,
  output logic [AW:0]      wgray,
  output logic [AW-1:0]    waddr,
  output logic             wpush,
  output logic             full_ir,
  output logic             afull
);

  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CMPW  = ((CW > OFS_W) ? CW : OFS_W) + 1;

  logic [CW-1:0]    wbin_q, wbin_d;
  logic [CW-1:0]    wgray_q, wgray_d;
  logic [CW-1:0]    rbin_s;
  logic [CW-1:0]    used, free;
  logic [OFS_W-1:0] af_reg_q, af_reg_d, af_eff;
  logic             full;

  // read pointer back to binary
  always_comb begin
    rbin_s[CW-1] = rgray_s[CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end
  end

  always_comb begin
    used     = wbin_q - rbin_s;
    free     = CW'(DEPTH) - used;
    full     = (used == CW'(DEPTH));
    wpush    = wen && !full;
    wbin_d   = wpush ? (wbin_q + 1'b1) : wbin_q;
    wgray_d  = wbin_d ^ (wbin_d >> 1);
    af_reg_d = af_we ? af_val : af_reg_q;
    af_eff   = (fsel == 2'd0) ? af_reg_q : OFS_W'(dflt_ofs(fsel));
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      af_reg_q <= '0;
    end else begin
      wbin_q   <= wbin_d;
      wgray_q  <= wgray_d;
      af_reg_q <= af_reg_d;
    end
  end

  assign wgray   = wgray_q;
  assign waddr   = wbin_q[AW-1:0];
  assign full_ir = fwft ? !full : full;
  assign afull   = (CMPW'(free) <= CMPW'(af_eff));

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    used <= CW'(DEPTH)); // R3

  AST_FULL_WRITE_DROPPED: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wen && full_ir != fwft) |=> $stable(wbin_q)); // R3

  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    !$stable(wgray_q) |-> $countones(wgray_q ^ $past(wgray_q)) == 1); // R10

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DW    = 36,
  parameter int AW    = 11,
  parameter int OFS_W = 8
) (
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             ren,
  input  logic             fwft,
  input  logic [1:0]       fsel,
  input  logic             ae_we,
  input  logic [OFS_W-1:0] ae_val,
  input  logic [AW:0]      wgray_s,
  input  logic [DW-1:0]    rdata,
  output logic [AW:0]      rgray,
  output logic [AW-1:0]    raddr,
  output logic             rpop,
  output logic             empty_or,
  output logic             aempty
);

  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CMPW  = ((CW > OFS_W) ? CW : OFS_W) + 1;

  logic [CW-1:0]    rbin_q, rbin_d;
  logic [CW-1:0]    rgray_q, rgray_d;
  logic [CW-1:0]    wbin_s;
  logic [CW-1:0]    avail, readable;
  logic [OFS_W-1:0] ae_reg_q, ae_reg_d, ae_eff;
  logic             ov_q, ov_d;
  logic             core_empty;

  always_comb begin
    wbin_s[CW-1] = wgray_s[CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end
  end

  always_comb begin
    avail      = wbin_s - rbin_q;
    core_empty = (avail == '0);
    if (fwft) begin
      rpop = !core_empty && (!ov_q || ren);
      if (rpop)     ov_d = 1'b1;
      else if (ren) ov_d = 1'b0;
      else          ov_d = ov_q;
    end else begin
      rpop = ren && !core_empty;
      ov_d = 1'b0;
    end
    rbin_d   = rpop ? (rbin_q + 1'b1) : rbin_q;
    rgray_d  = rbin_d ^ (rbin_d >> 1);
    readable = avail + {{(CW-1){1'b0}}, ov_q};
    ae_reg_d = ae_we ? ae_val : ae_reg_q;
    ae_eff   = (fsel == 2'd0) ? ae_reg_q : OFS_W'(dflt_ofs(fsel));
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      ov_q     <= 1'b0;
      ae_reg_q <= '0;
    end else begin
      rbin_q   <= rbin_d;
      rgray_q  <= rgray_d;
      ov_q     <= ov_d;
      ae_reg_q <= ae_reg_d;
    end
  end

  assign rgray    = rgray_q;
  assign raddr    = rbin_q[AW-1:0];
  assign empty_or = fwft ? ov_q : core_empty;
  assign aempty   = (CMPW'(readable) <= CMPW'(ae_eff));

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
    avail <= CW'(DEPTH)); // R4

  AST_EMPTY_READ_DROPPED: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!fwft && ren && empty_or) |=> ($stable(rbin_q) && $stable(rdata))); // R4

  AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    (fwft && empty_or && !ren) |=> (empty_or && $stable(rdata))); // R5

  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    !$stable(rgray_q) |-> $countones(rgray_q ^ $past(rgray_q)) == 1); // R10

endmodule

// File: rtl/dcfifo_dualtiming.sv
module dcfifo_dualtiming #(
  parameter int DW    = 36,
  parameter int AW    = 11,
  parameter int OFS_W = 8
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             fwft,
  input  logic [1:0]       fsel,
  input  logic             wen,
  input  logic [DW-1:0]    wdata,
  output logic             full_ir,
  output logic             afull,
  input  logic             af_ofs_we,
  input  logic [OFS_W-1:0] af_ofs_val,
  input  logic             ren,
  output logic [DW-1:0]    rdata,
  output logic             empty_or,
  output logic             aempty,
  input  logic             ae_ofs_we,
  input  logic [OFS_W-1:0] ae_ofs_val
);

  localparam int CW = AW + 1;

  logic          wrst_s, rrst_s;
  logic [CW-1:0] wgray, wgray_s, rgray, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wpush, rpop;

  // reset released synchronously in each domain
  dcf_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_s));
  dcf_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_s));

  // pointer crossings
  dcf_sync #(.W(CW)) u_r2w (.clk(wclk), .rst_n(wrst_s), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(CW)) u_w2r (.clk(rclk), .rst_n(rrst_s), .d(wgray), .q(wgray_s));

  dcf_wr_ctl #(.AW(AW), .OFS_W(OFS_W)) u_wr (
    .wclk    (wclk),
    .wrst_n  (wrst_s),
    .wen     (wen),
    .fwft    (fwft),
    .fsel    (fsel),
    .af_we   (af_ofs_we),
    .af_val  (af_ofs_val),
    .rgray_s (rgray_s),
    .wgray   (wgray),
    .waddr   (waddr),
    .wpush   (wpush),
    .full_ir (full_ir),
    .afull   (afull)
  );

  dcf_rd_ctl #(.DW(DW), .AW(AW), .OFS_W(OFS_W)) u_rd (
    .rclk     (rclk),
    .rrst_n   (rrst_s),
    .ren      (ren),
    .fwft     (fwft),
    .fsel     (fsel),
    .ae_we    (ae_ofs_we),
    .ae_val   (ae_ofs_val),
    .wgray_s  (wgray_s),
    .rdata    (rdata),
    .rgray    (rgray),
    .raddr    (raddr),
    .rpop     (rpop),
    .empty_or (empty_or),
    .aempty   (aempty)
  );

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk   (wclk),
    .we     (wpush),
    .waddr  (waddr),
    .wdata  (wdata),
    .rclk   (rclk),
    .rrst_n (rrst_s),
    .re     (rpop),
    .raddr  (raddr),
    .rdata  (rdata)
  );

  AST_RESET_CLEAR: assert property (@(posedge rclk)
    (!rrst_s && !fwft) |-> empty_or); // R12

endmodule

// File: tb/sim_dcfifo_dualtiming.sv
`timescale 1ns/100ps
module sim_dcfifo_dualtiming;

  localparam int DW = 36;
  localparam int AW = 4;
  localparam int OW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk, clk_b, async_on;
  logic wclk, rclk;
  logic rst_n, fwft;
  logic [1:0] fsel;
  logic wen, ren, af_ofs_we, ae_ofs_we;
  logic [DW-1:0] wdata, rdata;
  logic [OW-1:0] af_ofs_val, ae_ofs_val;
  logic full_ir, afull, empty_or, aempty;

  int checks = 0;
  int failures = 0;

  assign wclk = clk;
  assign rclk = async_on ? clk_b : clk;

  initial begin clk = 1'b0; forever #2 clk = ~clk; end
  initial begin clk_b = 1'b0; forever #3.5 clk_b = ~clk_b; end

  dcfifo_dualtiming #(.DW(DW), .AW(AW), .OFS_W(OW)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .fsel(fsel),
    .wen(wen), .wdata(wdata), .full_ir(full_ir), .afull(afull),
    .af_ofs_we(af_ofs_we), .af_ofs_val(af_ofs_val),
    .ren(ren), .rdata(rdata), .empty_or(empty_or), .aempty(aempty),
    .ae_ofs_we(ae_ofs_we), .ae_ofs_val(ae_ofs_val)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return {4'(i) ^ 4'h5, 32'(i) * 32'h9E37_79B1 + 32'h0000_1234};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode, input logic [1:0] sel, input logic asy);
    rst_n = 1'b0;
    wen = 1'b0; ren = 1'b0; af_ofs_we = 1'b0; ae_ofs_we = 1'b0;
    fwft = mode; fsel = sel; async_on = asy;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1'b1; wdata = d;
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic pull();
    @(negedge rclk);
    ren = 1'b1;
    @(negedge rclk);
    ren = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b1; wen = 1'b0; ren = 1'b0; wdata = '0;
    af_ofs_we = 1'b0; ae_ofs_we = 1'b0; af_ofs_val = '0; ae_ofs_val = '0;
    fwft = 1'b0; fsel = 2'd0; async_on = 1'b0;
    #1;

    // ---- standard mode, programmed offsets af=5 ae=3 ----
    do_reset(1'b0, 2'd0, 1'b0);
    chk("R12 empty after reset", 64'(empty_or), 64'(1));
    chk("R12 full after reset", 64'(full_ir), 64'(0));
    chk("R12 aempty after reset", 64'(aempty), 64'(1));
    chk("R12 afull after reset", 64'(afull), 64'(0));
    chk("R12 rdata after reset", 64'(rdata), 64'(0));

    @(negedge wclk); af_ofs_we = 1'b1; af_ofs_val = 8'd5;
    @(negedge wclk); af_ofs_we = 1'b0;
    @(negedge rclk); ae_ofs_we = 1'b1; ae_ofs_val = 8'd3;
    @(negedge rclk); ae_ofs_we = 1'b0;

    for (int n = 1; n <= DEPTH; n++) begin
      push(pat(n - 1));
      if (n == 1) begin
        chk("R10 empty held at write edge", 64'(empty_or), 64'(1));
        @(negedge rclk);
        chk("R10 empty held after one sync edge", 64'(empty_or), 64'(1));
        @(negedge rclk);
        chk("R10 empty falls after two sync edges", 64'(empty_or), 64'(0));
      end
      if (n == DEPTH - 5)
        chk("R10 afull rises at causing edge", 64'(afull), 64'(1));
      settle();
      chk("R3 full during fill", 64'(full_ir), 64'(n == DEPTH));
      chk("R8 afull during fill", 64'(afull), 64'((DEPTH - n) <= 5));
      chk("R2 empty during fill", 64'(empty_or), 64'(0));
      chk("R7 aempty during fill", 64'(aempty), 64'(n <= 3));
    end

    push(pat(999));
    settle();
    chk("R3 full held after dropped write", 64'(full_ir), 64'(1));

    for (int k = 1; k <= DEPTH; k++) begin
      pull();
      chk("R1 R2 std read data", 64'(rdata), 64'(pat(k - 1)));
      if (k == DEPTH)
        chk("R10 empty rises at causing edge", 64'(empty_or), 64'(1));
      settle();
      chk("R3 full during drain", 64'(full_ir), 64'(0));
      chk("R8 afull during drain", 64'(afull), 64'(k <= 5));
      chk("R2 empty during drain", 64'(empty_or), 64'(k == DEPTH));
      chk("R7 aempty during drain", 64'(aempty), 64'((DEPTH - k) <= 3));
    end

    pull();
    chk("R4 rdata kept on empty read", 64'(rdata), 64'(pat(DEPTH - 1)));
    settle();
    chk("R4 still empty after empty read", 64'(empty_or), 64'(1));
    chk("R2 rdata holds without ren", 64'(rdata), 64'(pat(DEPTH - 1)));

    // ---- simultaneous write and read on one edge ----
    for (int i = 0; i < 4; i++) push(pat(100 + i));
    settle();
    @(negedge wclk);
    wen = 1'b1; ren = 1'b1; wdata = pat(104);
    for (int k = 0; k < 20; k++) begin
      @(negedge wclk);
      chk("R11 same-edge read data", 64'(rdata), 64'(pat(100 + k)));
      wdata = pat(105 + k);
    end
    wen = 1'b0; ren = 1'b0;
    settle();
    for (int k = 0; k < 4; k++) begin
      pull();
      chk("R11 words left after same-edge run", 64'(rdata), 64'(pat(120 + k)));
    end
    settle();
    chk("R11 empty after drain", 64'(empty_or), 64'(1));

    // ---- fall-through mode, offsets 8 (fsel=1) ----
    do_reset(1'b1, 2'd1, 1'b0);
    chk("R12 fwft output-ready low after reset", 64'(empty_or), 64'(0));
    chk("R12 fwft input-ready after reset", 64'(full_ir), 64'(1));
    chk("R12 fwft aempty after reset", 64'(aempty), 64'(1));
    for (int n = 1; n <= DEPTH + 1; n++) begin
      push(pat(200 + n - 1));
      settle();
      chk("R5 output-ready without read", 64'(empty_or), 64'(1));
      chk("R5 head word shown", 64'(rdata), 64'(pat(200)));
      chk("R6 input-ready", 64'(full_ir), 64'((n - 1) < DEPTH));
      chk("R8 R9 fwft afull", 64'(afull), 64'((DEPTH - (n - 1)) <= 8));
      chk("R7 R9 fwft aempty", 64'(aempty), 64'(n <= 8));
    end
    push(pat(777));
    settle();
    chk("R6 input-ready low after dropped write", 64'(full_ir), 64'(0));
    for (int k = 0; k <= DEPTH; k++) begin
      chk("R1 R5 fwft head before read", 64'(rdata), 64'(pat(200 + k)));
      pull();
      settle();
      chk("R5 output-ready after read", 64'(empty_or), 64'(k < DEPTH));
      chk("R7 fwft aempty drain", 64'(aempty), 64'((DEPTH - k) <= 8));
    end
    pull();
    settle();
    chk("R4 fwft read while not ready", 64'(rdata), 64'(pat(200 + DEPTH)));
    chk("R4 fwft still not ready", 64'(empty_or), 64'(0));

    // ---- default offsets for codes 2 and 3 ----
    do_reset(1'b0, 2'd2, 1'b0);
    chk("R9 fsel2 afull at zero words", 64'(afull), 64'(1));
    for (int n = 0; n < DEPTH; n++) push(pat(n));
    settle();
    chk("R9 fsel2 aempty at depth", 64'(aempty), 64'(1));
    do_reset(1'b0, 2'd3, 1'b0);
    for (int n = 0; n < 8; n++) push(pat(n));
    settle();
    chk("R9 fsel3 aempty at half", 64'(aempty), 64'(1));
    chk("R9 fsel3 afull at half", 64'(afull), 64'(1));

    // ---- unrelated clocks ----
    do_reset(1'b0, 2'd0, 1'b1);
    for (int n = 0; n < DEPTH; n++) push(pat(300 + n));
    settle();
    chk("R3 async full", 64'(full_ir), 64'(1));
    for (int k = 0; k < DEPTH; k++) begin
      pull();
      chk("R1 async read order", 64'(rdata), 64'(pat(300 + k)));
    end
    settle();
    chk("R2 async empty at end", 64'(empty_or), 64'(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule